// File: doc/BRIEF.md
# Multiplexed Address/Data Register Port

This block is a slave port through which a host reaches a small internal register file over a narrow parallel bus. Eight lines carry both the register index and the data byte. A phase-select line tells the slave which of the two the current cycle carries. Every access takes two cycles. First the host writes the register index while phase select is high. Then it reads or writes the data byte while phase select is low. The index stays latched, so any number of data cycles may follow one index cycle.

The host pins are asynchronous to the system clock. Chip select, phase select, the two active-low strobes and the eight data lines all pass through a two-flop synchroniser. A transfer is taken once, on the falling edge of the synchronised strobe. The slave answers with an active-low ready that stays low until the strobe is released. The data lines are split into an input, an output and an output enable, so the pad ring can build the bidirectional buffer. A level interrupt, active low, reports core events that are allowed by a mask held in register 0. The writable registers are also presented to the core on a flat configuration bus.

Top module: `mrp_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), bus_rdy_n and bus_irq_n are 1, bus_d_oe is 0 when no read is in progress, all writable registers read as 0x00 and the latched index is 0.
- R2: Suppose a strobe is first sampled low at rising edge m, after being sampled high at edge m-1. The transfer is then taken at edge m+2, and bus_rdy_n is low from that edge on. Chip select, phase select and the data lines are used as sampled at edge m.
- R3: A write-strobe cycle with chip select low and phase select high latches bus_d_in[3:0] as the register index. Bits 7:4 are ignored.
- R4: The latched index holds across any number of data cycles and changes only in an index cycle.
- R5: A write-strobe cycle with phase select low, to index i with i below NUM_RW, stores the byte in register i. The byte appears on cfg_regs[8i+7:8i].
- R6: A read-strobe cycle with phase select low returns the selected register on bus_d_out while bus_rdy_n is low.
- R7: Index 0xF reads as the REVISION parameter (default 0x5A). Writes to it have no effect.
- R8: Indices from NUM_RW to 0xE read as 0x00. Writes to them leave every register and cfg_regs unchanged.
- R9: bus_d_oe is 1 exactly while bus_cs_n is 0, bus_rd_n is 0 and bus_idx_sel is 0, and 0 at all other times.
- R10: bus_rdy_n goes high at the second rising edge after the released strobe is first sampled high.
- R11: Strobes given while bus_cs_n is high produce no ready and no register change.
- R12: bus_irq_n is low in the cycle after an edge at which evt_in AND register 0 (the mask) is nonzero, and high otherwise.
- R13: If both strobes fall together, no transfer is taken and no ready is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_cs_n | input | 1 | Chip select from host, active low |
| bus_idx_sel | input | 1 | 1: index cycle, 0: data cycle |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_d_in | input | DATA_W | Shared address/data lines, input side |
| bus_d_out | output | DATA_W | Read data toward the pad |
| bus_d_oe | output | 1 | Pad output enable for bus_d_out |
| bus_rdy_n | output | 1 | Ready handshake, active low |
| bus_irq_n | output | 1 | Interrupt to host, active low |
| evt_in | input | DATA_W | Core event levels, masked by register 0 |
| cfg_regs | output | NUM_RW*DATA_W | Writable registers, register i in byte i |

## Verification
The bench measures the strobe-to-ready and release-to-idle latency of every transfer. A synchroniser stage too many or too few shows up as a count other than three. It writes to the revision index and to unmapped indices, then reads back and watches the configuration bus, so a decoder that aliases unmapped indices onto real registers gets caught. It drives strobes with chip select high and both strobes at once, which would give a spurious ready or a corrupted register in a design that does not qualify the edge. It also reads without a fresh index cycle and sends index bytes with the upper bits set, so an index that is lost or taken too wide returns the wrong register.

// File: rtl/mrp_pkg.sv
// Shared constants and types for the multiplexed register port.
// Assumes a 4-bit register index with the top index reserved for revision.
package mrp_pkg;
    localparam int IDX_W = 4;
    localparam logic [IDX_W-1:0] REV_IDX = '1;

    typedef enum logic [1:0] {
        XF_NONE  = 2'd0,
        XF_INDEX = 2'd1,
        XF_WRITE = 2'd2,
        XF_READ  = 2'd3
    } xfer_e;
endpackage

// File: rtl/mrp_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous host pins.
// Assumes the host holds the pins stable for longer than STAGES clocks.
module mrp_sync #(
    parameter int           W      = 1,
    parameter int           STAGES = 2,
    parameter logic [W-1:0] IDLE   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Capture raw pins into the first stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= IDLE;
                else        chain[g] <= d;
            end
        end else begin : g_next
            // Move the value one stage down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= IDLE;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mrp_decode.sv
// Strobe edge detector and ready generator.
// Takes synchronised pins, finds the fall of the combined strobe, and
// classifies the transfer. Assumes pins have already been synchronised.
module mrp_decode
    import mrp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cs_n_s,
    input  logic  sel_s,
    input  logic  wr_n_s,
    input  logic  rd_n_s,
    output xfer_e xfer,
    output logic  rdy_n
);
    logic wr_n_p, rd_n_p;
    logic any_now, any_prev, single, take;
    logic rdy_q;

    // Keep last cycle's strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_n_p <= 1'b1;
            rd_n_p <= 1'b1;
        end else begin
            wr_n_p <= wr_n_s;
            rd_n_p <= rd_n_s;
        end
    end

    // Detect a single strobe falling while chip select is active.
    always_comb begin
        any_now  = !wr_n_s || !rd_n_s;
        any_prev = !wr_n_p || !rd_n_p;
        single   = wr_n_s ^ rd_n_s;
        take     = any_now && !any_prev && single && !cs_n_s;
    end

    // Classify the taken transfer from phase select and strobe.
    always_comb begin
        xfer = XF_NONE;
        if (take) begin
            if (!wr_n_s) xfer = sel_s ? XF_INDEX : XF_WRITE;
            else if (!sel_s) xfer = XF_READ;
        end
    end

    // Raise ready on a taken transfer, drop it when the strobe is gone.
    always_ff @(posedge clk) begin
        if (!rst_n)        rdy_q <= 1'b0;
        else if (take)     rdy_q <= 1'b1;
        else if (!any_now) rdy_q <= 1'b0;
    end

    assign rdy_n = !rdy_q;

    // R2 / R13: ready only ever falls right after a taken transfer.
    a_r2_rdy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_n) |-> $past(take));

    // R10: a released strobe clears ready at the next edge.
    a_r10_rdy_release: assert property (@(posedge clk) disable iff (!rst_n)
        !any_now |=> rdy_n);
endmodule

// File: rtl/mrp_regfile.sv
// Register file behind the port: index latch, writable bytes, revision
// code, read-data capture and masked interrupt. Register 0 is the mask.
// Assumes transfers arrive as one-cycle xfer pulses.
module mrp_regfile
    import mrp_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter int                NUM_RW   = 4,
    parameter logic [DATA_W-1:0] REVISION = 8'h5A
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  xfer_e                    xfer,
    input  logic [DATA_W-1:0]        din,
    input  logic [DATA_W-1:0]        evt_in,
    output logic [DATA_W-1:0]        rd_data,
    output logic [NUM_RW*DATA_W-1:0] cfg,
    output logic                     irq_n
);
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] regs [NUM_RW];
    logic [DATA_W-1:0] rd_q, rd_mux;
    logic              irq_q;

    // Latch the register index in an index cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)               idx_q <= '0;
        else if (xfer == XF_INDEX) idx_q <= din[IDX_W-1:0];
    end

    for (genvar g = 0; g < NUM_RW; g++) begin : g_reg
        // Store a data byte when this register is the latched index.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (xfer == XF_WRITE && idx_q == IDX_W'(g))
                regs[g] <= din;
        end
        assign cfg[g*DATA_W +: DATA_W] = regs[g];
    end

    // Select read data: revision, a writable register, or zero.
    always_comb begin
        rd_mux = '0;
        if (idx_q == REV_IDX) rd_mux = REVISION;
        for (int i = 0; i < NUM_RW; i++)
            if (idx_q == IDX_W'(i)) rd_mux = regs[i];
    end

    // Capture read data when a read transfer is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)               rd_q <= '0;
        else if (xfer == XF_READ) rd_q <= rd_mux;
    end

    // Register the masked interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(evt_in & regs[0]);
    end

    assign rd_data = rd_q;
    assign irq_n   = !irq_q;

    // R4: index only changes in an index cycle.
    a_r4_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        xfer != XF_INDEX |=> $stable(idx_q));

    // R7 / R8: writes to revision or unmapped indices change nothing.
    a_r8_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer == XF_WRITE && int'(idx_q) >= NUM_RW) |=> $stable(cfg));

    // R6: returned data only moves on a taken read.
    a_r6_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        xfer != XF_READ |=> $stable(rd_data));
endmodule

// File: rtl/mrp_top.sv
// Multiplexed address/data register port, top level.
// Synchronises host pins, decodes transfers, and serves the register file.
// Assumes the pad ring builds the bidirectional buffer from d_out / d_oe.
module mrp_top
    import mrp_pkg::*;
#(
    parameter int                DATA_W      = 8,
    parameter int                NUM_RW      = 4,
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] REVISION    = 8'h5A
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_cs_n,
    input  logic                     bus_idx_sel,
    input  logic                     bus_wr_n,
    input  logic                     bus_rd_n,
    input  logic [DATA_W-1:0]        bus_d_in,
    output logic [DATA_W-1:0]        bus_d_out,
    output logic                     bus_d_oe,
    output logic                     bus_rdy_n,
    output logic                     bus_irq_n,
    input  logic [DATA_W-1:0]        evt_in,
    output logic [NUM_RW*DATA_W-1:0] cfg_regs
);
    localparam int CTRL_W = 4;
    localparam logic [CTRL_W-1:0] CTRL_IDLE = 4'b1011;

    logic [CTRL_W-1:0] ctrl_s;
    logic [DATA_W-1:0] din_s;
    xfer_e             xfer;

    mrp_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .IDLE(CTRL_IDLE)) u_sync_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bus_cs_n, bus_idx_sel, bus_wr_n, bus_rd_n}),
        .q     (ctrl_s)
    );

    mrp_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .IDLE('0)) u_sync_data (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_d_in),
        .q     (din_s)
    );

    mrp_decode u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n_s (ctrl_s[3]),
        .sel_s  (ctrl_s[2]),
        .wr_n_s (ctrl_s[1]),
        .rd_n_s (ctrl_s[0]),
        .xfer   (xfer),
        .rdy_n  (bus_rdy_n)
    );

    mrp_regfile #(.DATA_W(DATA_W), .NUM_RW(NUM_RW), .REVISION(REVISION)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .xfer    (xfer),
        .din     (din_s),
        .evt_in  (evt_in),
        .rd_data (bus_d_out),
        .cfg     (cfg_regs),
        .irq_n   (bus_irq_n)
    );

    // Drive the pads only during a selected read data cycle.
    assign bus_d_oe = !bus_cs_n && !bus_rd_n && !bus_idx_sel;

    // R11: no ready can start while chip select has been idle through the sync.
    a_r11_cs_gates_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_s[3] |=> !$fell(bus_rdy_n));
endmodule

// File: tb/sim_mrp_top.sv
// Bench for mrp_top: a behavioural per-clock reference model plus directed
// host transactions.
module sim_mrp_top;
    localparam int NUM_RW = 4;
    localparam logic [7:0] REV = 8'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sel = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
    logic [7:0] din = 8'h00, evt = 8'h00;
    logic [7:0] d_out;
    logic d_oe, rdy_n, irq_n;
    logic [NUM_RW*8-1:0] cfg;

    int checks = 0, fails = 0, cyc = 0;

    always #10 clk = ~clk;

    mrp_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_idx_sel(sel),
        .bus_wr_n(wr_n), .bus_rd_n(rd_n), .bus_d_in(din), .bus_d_out(d_out),
        .bus_d_oe(d_oe), .bus_rdy_n(rdy_n), .bus_irq_n(irq_n),
        .evt_in(evt), .cfg_regs(cfg)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // ---------------- reference model ----------------
    logic h_cs[4], h_sel[4], h_wr[4], h_rd[4];
    logic [7:0] h_din[4];
    logic [7:0] m_regs[NUM_RW];
    logic [3:0] m_idx;
    logic [7:0] m_rdq;
    logic m_rdy, m_irq;

    function automatic logic [7:0] m_read(input logic [3:0] i);
        if (i == 4'hF) return REV;
        if (int'(i) < NUM_RW) return m_regs[i];
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                h_cs[i] = 1; h_sel[i] = 0; h_wr[i] = 1; h_rd[i] = 1; h_din[i] = 0;
            end
            for (int i = 0; i < NUM_RW; i++) m_regs[i] = 0;
            m_idx = 0; m_rdq = 0; m_rdy = 0; m_irq = 0;
        end else begin
            for (int i = 3; i > 0; i--) begin
                h_cs[i] = h_cs[i-1]; h_sel[i] = h_sel[i-1]; h_wr[i] = h_wr[i-1];
                h_rd[i] = h_rd[i-1]; h_din[i] = h_din[i-1];
            end
            h_cs[0] = cs_n; h_sel[0] = sel; h_wr[0] = wr_n; h_rd[0] = rd_n; h_din[0] = din;
            begin
                bit low2, low3, take;
                low2 = !h_wr[2] || !h_rd[2];
                low3 = !h_wr[3] || !h_rd[3];
                take = low2 && !low3 && !h_cs[2] && (h_wr[2] != h_rd[2]);
                m_irq = |(evt & m_regs[0]);
                if (take) begin
                    if (!h_wr[2]) begin
                        if (h_sel[2]) m_idx = h_din[2][3:0];
                        else if (int'(m_idx) < NUM_RW) m_regs[m_idx] = h_din[2];
                    end else if (!h_sel[2]) begin
                        m_rdq = m_read(m_idx);
                    end
                end
                if (take) m_rdy = 1;
                else if (!low2) m_rdy = 0;
            end
        end
    end

    // Compare the design against the model on every clock.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [NUM_RW*8-1:0] m_cfg;
            logic exp_oe;
            for (int i = 0; i < NUM_RW; i++) m_cfg[i*8 +: 8] = m_regs[i];
            exp_oe = !cs_n && !rd_n && !sel;
            chk(rdy_n === !m_rdy, "R10", int'(rdy_n), int'(!m_rdy));
            chk(irq_n === !m_irq, "R12", int'(irq_n), int'(!m_irq));
            chk(d_oe === exp_oe, "R9", int'(d_oe), int'(exp_oe));
            chk(cfg === m_cfg, "R5", int'(cfg), int'(m_cfg));
            if (exp_oe && m_rdy) chk(d_out === m_rdq, "R6", int'(d_out), int'(m_rdq));
        end
    end

    // ---------------- host tasks ----------------
    task automatic host_cycle(input bit is_sel, input bit is_rd, input logic [7:0] d,
                              output logic [7:0] q);
        int n;
        @(negedge clk); cs_n = 0; sel = is_sel; din = d;
        @(negedge clk); if (is_rd) rd_n = 0; else wr_n = 0;
        n = 0;
        do begin @(negedge clk); n++; end while (rdy_n && n < 40);
        chk(n == 3, "R2", n, 3);
        q = d_out;
        if (is_rd && !is_sel) chk(d_oe == 1'b1, "R9", int'(d_oe), 1);
        else chk(d_oe == 1'b0, "R9", int'(d_oe), 0);
        rd_n = 1; wr_n = 1;
        n = 0;
        do begin @(negedge clk); n++; end while (!rdy_n && n < 40);
        chk(n == 3, "R10", n, 3);
        cs_n = 1; sel = 0;
    endtask

    task automatic set_idx(input logic [7:0] i);
        logic [7:0] dummy;
        host_cycle(1'b1, 1'b0, i, dummy);
    endtask

    task automatic wr_byte(input logic [7:0] d);
        logic [7:0] dummy;
        host_cycle(1'b0, 1'b0, d, dummy);
    endtask

    task automatic rd_byte(output logic [7:0] q);
        host_cycle(1'b0, 1'b1, 8'h00, q);
    endtask

    // Hold a stimulus for several clocks and confirm no ready appears.
    task automatic no_ready_window(input string req);
        bit seen = 0;
        for (int i = 0; i < 6; i++) begin @(negedge clk); if (!rdy_n) seen = 1; end
        chk(!seen, req, int'(seen), 0);
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        logic [7:0] r;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(rdy_n === 1'b1, "R1", int'(rdy_n), 1);
        chk(irq_n === 1'b1, "R1", int'(irq_n), 1);
        chk(d_oe === 1'b0, "R1", int'(d_oe), 0);
        chk(cfg === '0, "R1", int'(cfg), 0);
        rd_byte(r); chk(r == 8'h00, "R1", r, 0);

        // R5 / R6: write and read back register 1
        set_idx(8'h01); wr_byte(8'hA5); rd_byte(r);
        chk(r == 8'hA5, "R6", r, 8'hA5);
        chk(cfg[15:8] == 8'hA5, "R5", cfg[15:8], 8'hA5);

        // R4: index persists across data cycles
        set_idx(8'h02); wr_byte(8'h3C); rd_byte(r);
        chk(r == 8'h3C, "R4", r, 8'h3C);
        wr_byte(8'hC3); rd_byte(r);
        chk(r == 8'hC3, "R4", r, 8'hC3);

        // R3: upper bits of index byte ignored
        set_idx(8'h01); set_idx(8'hF2); rd_byte(r);
        chk(r == 8'hC3, "R3", r, 8'hC3);

        // R7: revision index read-only
        set_idx(8'h0F); rd_byte(r); chk(r == REV, "R7", r, REV);
        wr_byte(8'h00); rd_byte(r); chk(r == REV, "R7", r, REV);

        // R8: unmapped index
        set_idx(8'h09); wr_byte(8'hFF); rd_byte(r);
        chk(r == 8'h00, "R8", r, 0);
        chk(cfg == 32'h00C3A500, "R8", int'(cfg), 32'h00C3A500);

        // R11: strobes with chip select high are ignored
        set_idx(8'h03);
        @(negedge clk); din = 8'h77; @(negedge clk); wr_n = 0;
        no_ready_window("R11");
        wr_n = 1; repeat (3) @(negedge clk);
        rd_byte(r); chk(r == 8'h00, "R11", r, 0);

        // R13: both strobes together are ignored
        @(negedge clk); cs_n = 0; din = 8'h66; @(negedge clk); wr_n = 0; rd_n = 0;
        no_ready_window("R13");
        wr_n = 1; rd_n = 1; repeat (3) @(negedge clk); cs_n = 1;
        rd_byte(r); chk(r == 8'h00, "R13", r, 0);

        // R9: read strobe in an index cycle keeps the bus tri-stated
        host_cycle(1'b1, 1'b1, 8'h00, r);

        // R12: masked interrupt
        set_idx(8'h00); wr_byte(8'h04);
        @(negedge clk); evt = 8'h04; repeat (2) @(negedge clk);
        chk(irq_n == 1'b0, "R12", int'(irq_n), 0);
        evt = 8'h02; repeat (2) @(negedge clk);
        chk(irq_n == 1'b1, "R12", int'(irq_n), 1);
        evt = 8'h06; repeat (2) @(negedge clk);
        chk(irq_n == 1'b0, "R12", int'(irq_n), 0);
        wr_byte(8'h00); repeat (2) @(negedge clk);
        chk(irq_n == 1'b1, "R12", int'(irq_n), 1);
        evt = 8'h00;

        // R5: pattern sweep over all writable registers
        for (int i = 0; i < NUM_RW; i++) begin
            set_idx(8'(i)); wr_byte(8'(8'h11 * (i + 3)));
        end
        for (int i = NUM_RW - 1; i >= 0; i--) begin
            set_idx(8'(i)); rd_byte(r);
            chk(r == 8'(8'h11 * (i + 3)), "R5", r, 8'(8'h11 * (i + 3)));
        end

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule